// File: doc/BRIEF.md
# PLL Lock-Wait Startup Delay Controller

This block keeps the rest of the chip from running while a phase-locked loop settles. There are three situations in which the loop has to settle. The first is when the power-on reset is released. The second is when the chip leaves a low-power halt state. The third is when software changes the loop's multiplier select. In every case the block counts a fixed number of oscillator cycles, and it counts only while the oscillator monitor reports that the oscillator is running. Any pause in that indication sends the count back to zero.

Each situation has a different effect on the outputs:

- **Power-on:** the internal reset is held through the count. It then stays asserted for a short tail measured in system-clock cycles.
- **Halt exit:** the system clock is gated for the length of the count.
- **Multiplier change:** the clock keeps running for a few synchronizing cycles. It is then gated for the length of the count.

The count itself runs in the oscillator domain. The release indications cross into the system-clock domain through a multi-flop synchronizer. The gate is built from a latch that is transparent while the clock is low, so the gated clock only ever carries whole pulses. The block also holds the multiplier select bit that it guards.

Top module: `pll_lockwait`

## Requirements
- R1: While `por_n` is low, `rst_hold_o` is 1, `clk_en_o` is 1 and `mult_sel_o` is 1 (1 selects the ×4 multiplier and 0 selects ×8).
- R2: The count is 4096 oscillator edges sampled with `osc_ok` high. Take the case where `sys_clk` carries the same clock as `osc_clk` and `osc_ok` stays high after `por_n` rises. Then `rst_hold_o` falls at the 4106th rising edge after release: 4096 counted edges, plus 2 synchronizer edges, plus the tail.
- R3: An edge sampled with `osc_ok` low clears the count. Counting restarts at the next edge sampled with `osc_ok` high. This also covers an oscillator that has not yet started when reset is released.
- R4: After the count completes, the reset tail lasts 8 system-clock cycles before `rst_hold_o` falls.
- R5: A `halt_exit` pulse while running makes `clk_en_o` fall 2 edges later. With `osc_ok` steady, `clk_en_o` then stays low for exactly 4096 edges.
- R6: A `mult_wr` pulse whose `mult_wdata` differs from `mult_sel_o` updates `mult_sel_o` at that edge. The clock keeps running for 2 more edges, and `clk_en_o` falls 4 edges after the write. It then stays low for 4096 edges.
- R7: A `mult_wr` pulse whose `mult_wdata` equals `mult_sel_o` has no effect: `clk_en_o` stays 1.
- R8: Any `halt_exit` or `mult_wr` pulse outside the running state is ignored. This includes pulses during a hold. `mult_sel_o` keeps its value and the hold keeps its length.
- R9: `gclk_o` produces a full high pulse at a `sys_clk` rising edge exactly when `clk_en_o` was 1 during the preceding low phase. At all other times it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator reference clock |
| sys_clk | input | 1 | System clock before gating |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| osc_ok | input | 1 | Oscillator monitor reports oscillation, osc_clk domain |
| halt_exit | input | 1 | One-cycle pulse: leaving halt state |
| mult_wr | input | 1 | One-cycle pulse: multiplier select written |
| mult_wdata | input | 1 | Value written to the multiplier select |
| rst_hold_o | output | 1 | Internal reset hold, sys_clk domain |
| clk_en_o | output | 1 | Synchronized clock enable, sys_clk domain |
| gclk_o | output | 1 | Glitch-free gated system clock |
| mult_sel_o | output | 1 | Current multiplier select (1 = ×4, 0 = ×8) |

## Verification
Suppose the count register holds a wrong value, or fails to clear on a pause. The hold length or the reset release edge then moves away from its expected position, and this shows up 4096 to 4106 edges after the trigger. A stuck or wrongly taken state transition has a faster effect: it appears at `clk_en_o` within 2 to 4 edges of a trigger, or at `mult_sel_o` on the following edge. A bad gate latch shows up as extra or missing `gclk_o` pulses, counted against `clk_en_o` across each hold window.

// File: rtl/pll_lockwait_pkg.sv
package pll_lockwait_pkg;
   typedef enum logic [1:0] {
      LW_BOOT = 2'd0,
      LW_RUN  = 2'd1,
      LW_SYNC = 2'd2,
      LW_HOLD = 2'd3
   } lw_state_e;
endpackage

// File: rtl/lw_sync.sv
module lw_sync #(
   parameter int                 WIDTH   = 1,
   parameter int                 STAGES  = 2,
   parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lw_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= {STAGES{RST_VAL}};
      else        stg_q <= {stg_q[STAGES-2:0], d};
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/lw_osc_ctrl.sv
module lw_osc_ctrl
   import pll_lockwait_pkg::*;
#(
   parameter int   WAIT_CYC = 4096,
   parameter int   SYNC_CYC = 2,
   parameter logic MULT_RST = 1'b1
) (
   input  logic osc_clk,
   input  logic por_n,
   input  logic osc_ok,
   input  logic halt_exit,
   input  logic mult_wr,
   input  logic mult_wdata,
   output logic boot_done,
   output logic run_en,
   output logic mult_sel
);
   localparam int CNT_W  = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1;
   localparam int SCNT_W = (SYNC_CYC > 1) ? $clog2(SYNC_CYC) : 1;
   localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(WAIT_CYC - 1);
   localparam logic [SCNT_W-1:0] SCNT_LAST = SCNT_W'(SYNC_CYC - 1);

   generate
      if (WAIT_CYC < 2) begin : g_bad_wait
         $error("lw_osc_ctrl: WAIT_CYC must be at least 2");
      end
      if (SYNC_CYC < 1) begin : g_bad_sync
         $error("lw_osc_ctrl: SYNC_CYC must be at least 1");
      end
   endgenerate

   lw_state_e         st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [SCNT_W-1:0] scnt_q;
   logic              mult_q;
   logic              counting;

   assign counting = (st_q == LW_BOOT) || (st_q == LW_HOLD);

   always_ff @(posedge osc_clk or negedge por_n) begin
      if (!por_n) begin
         st_q   <= LW_BOOT;
         cnt_q  <= '0;
         scnt_q <= '0;
         mult_q <= MULT_RST;
      end else begin
         unique case (st_q)
            LW_BOOT, LW_HOLD: begin
               if (!osc_ok) begin
                  cnt_q <= '0;
               end else if (cnt_q == CNT_LAST) begin
                  cnt_q <= '0;
                  st_q  <= LW_RUN;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            LW_RUN: begin
               if (halt_exit) begin
                  cnt_q <= '0;
                  st_q  <= LW_HOLD;
               end else if (mult_wr && (mult_wdata != mult_q)) begin
                  mult_q <= mult_wdata;
                  scnt_q <= '0;
                  st_q   <= LW_SYNC;
               end
            end
            LW_SYNC: begin
               if (scnt_q == SCNT_LAST) begin
                  cnt_q <= '0;
                  st_q  <= LW_HOLD;
               end else begin
                  scnt_q <= scnt_q + 1'b1;
               end
            end
            default: st_q <= LW_BOOT;
         endcase
      end
   end

   assign boot_done = (st_q != LW_BOOT);
   assign run_en    = (st_q != LW_HOLD);
   assign mult_sel  = mult_q;

   // R3
   pause_clears_chk: assert property (@(posedge osc_clk) disable iff (!por_n)
      (counting && !osc_ok) |=> (cnt_q == '0));
   // R5
   halt_enters_hold_chk: assert property (@(posedge osc_clk) disable iff (!por_n)
      (st_q == LW_RUN && halt_exit) |=> (st_q == LW_HOLD));
   // R6
   mult_change_sync_chk: assert property (@(posedge osc_clk) disable iff (!por_n)
      (mult_q != $past(mult_q)) |-> (st_q == LW_SYNC));
   // R7
   same_write_quiet_chk: assert property (@(posedge osc_clk) disable iff (!por_n)
      (st_q == LW_RUN && !halt_exit && mult_wr && mult_wdata == mult_q) |=> (st_q == LW_RUN));
   // R8
   mult_frozen_chk: assert property (@(posedge osc_clk) disable iff (!por_n)
      (st_q != LW_RUN) |=> (mult_q == $past(mult_q)));
endmodule

// File: rtl/lw_sys_gate.sv
module lw_sys_gate #(
   parameter int TAIL_CYC = 8
) (
   input  logic sys_clk,
   input  logic por_n,
   input  logic boot_s,
   input  logic run_s,
   output logic rst_hold,
   output logic gclk
);
   localparam int TCNT_W = (TAIL_CYC > 1) ? $clog2(TAIL_CYC) : 1;
   localparam logic [TCNT_W-1:0] TCNT_LAST = TCNT_W'(TAIL_CYC - 1);

   generate
      if (TAIL_CYC < 1) begin : g_bad_tail
         $error("lw_sys_gate: TAIL_CYC must be at least 1");
      end
   endgenerate

   logic [TCNT_W-1:0] tcnt_q;
   logic              hold_q;
   logic              en_lat;

   always_ff @(posedge sys_clk or negedge por_n) begin
      if (!por_n) begin
         tcnt_q <= '0;
         hold_q <= 1'b1;
      end else if (boot_s && hold_q) begin
         if (tcnt_q == TCNT_LAST) hold_q <= 1'b0;
         else                     tcnt_q <= tcnt_q + 1'b1;
      end
   end

   always_latch begin
      if (!sys_clk) en_lat = run_s;
   end

   assign gclk     = sys_clk & en_lat;
   assign rst_hold = hold_q;

   // R4
   release_needs_count_chk: assert property (@(posedge sys_clk) disable iff (!por_n)
      !hold_q |-> boot_s);
   // R4
   hold_never_returns_chk: assert property (@(posedge sys_clk) disable iff (!por_n)
      !$past(hold_q) |-> !hold_q);
endmodule

// File: rtl/pll_lockwait.sv
module pll_lockwait #(
   parameter int   WAIT_CYC    = 4096,
   parameter int   TAIL_CYC    = 8,
   parameter int   SYNC_CYC    = 2,
   parameter int   SYNC_STAGES = 2,
   parameter logic MULT_RST    = 1'b1
) (
   input  logic osc_clk,
   input  logic sys_clk,
   input  logic por_n,
   input  logic osc_ok,
   input  logic halt_exit,
   input  logic mult_wr,
   input  logic mult_wdata,
   output logic rst_hold_o,
   output logic clk_en_o,
   output logic gclk_o,
   output logic mult_sel_o
);
   logic       boot_done;
   logic       run_en;
   logic [1:0] xfer_s;

   lw_osc_ctrl #(
      .WAIT_CYC (WAIT_CYC),
      .SYNC_CYC (SYNC_CYC),
      .MULT_RST (MULT_RST)
   ) i_osc_ctrl (
      .osc_clk    (osc_clk),
      .por_n      (por_n),
      .osc_ok     (osc_ok),
      .halt_exit  (halt_exit),
      .mult_wr    (mult_wr),
      .mult_wdata (mult_wdata),
      .boot_done  (boot_done),
      .run_en     (run_en),
      .mult_sel   (mult_sel_o)
   );

   lw_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b01)
   ) i_sync (
      .clk   (sys_clk),
      .rst_n (por_n),
      .d     ({boot_done, run_en}),
      .q     (xfer_s)
   );

   lw_sys_gate #(
      .TAIL_CYC (TAIL_CYC)
   ) i_gate (
      .sys_clk  (sys_clk),
      .por_n    (por_n),
      .boot_s   (xfer_s[1]),
      .run_s    (xfer_s[0]),
      .rst_hold (rst_hold_o),
      .gclk     (gclk_o)
   );

   assign clk_en_o = xfer_s[0];
endmodule

// File: tb/test_pll_lockwait.sv
`timescale 1ns/1ps
module test_pll_lockwait;
   localparam int WAIT = 4096;

   logic clk = 1'b0;
   logic por_n, osc_ok, halt_exit, mult_wr, mult_wdata;
   logic rst_hold_o, clk_en_o, gclk_o, mult_sel_o;
   int   n_chk = 0, n_fail = 0, gcnt = 0;
   bit   exp_mult = 1'b1;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge gclk_o) gcnt++;

   pll_lockwait i_pll_lockwait (
      .osc_clk(clk), .sys_clk(clk), .por_n(por_n), .osc_ok(osc_ok),
      .halt_exit(halt_exit), .mult_wr(mult_wr), .mult_wdata(mult_wdata),
      .rst_hold_o(rst_hold_o), .clk_en_o(clk_en_o), .gclk_o(gclk_o),
      .mult_sel_o(mult_sel_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   function automatic int exp_release(input int pre, input int d, input int len);
      int last = 0;
      if (pre > 0) last = pre;
      if (len > 0 && d + len - 1 > last) last = d + len - 1;
      return last + WAIT + 2 + 8;
   endfunction

   function automatic int exp_low(input int d, input int len);
      return WAIT + ((len > 0) ? d + len - 1 : 0);
   endfunction

   // power-on sequence: pre = edges with oscillator not yet running, plus one mid pause
   task automatic por_run(input int pre, input int d, input int len);
      int fall = -1;
      @(negedge clk);
      por_n = 1'b0; osc_ok = 1'b0; halt_exit = 1'b0; mult_wr = 1'b0; mult_wdata = 1'b0;
      repeat (3) @(negedge clk);
      chk(rst_hold_o == 1'b1, "R1 rst_hold", rst_hold_o, 1);
      chk(clk_en_o == 1'b1,   "R1 clk_en",   clk_en_o, 1);
      chk(mult_sel_o == 1'b1, "R1 mult_sel", mult_sel_o, 1);
      exp_mult = 1'b1;
      por_n = 1'b1;
      for (int k = 1; k < 20000 && fall < 0; k++) begin
         if (k > 1 && rst_hold_o == 1'b0) fall = k - 1;
         osc_ok = !((k <= pre) || (len > 0 && k >= d && k < d + len));
         @(posedge clk);
         @(negedge clk);
      end
      chk(fall == exp_release(pre, d, len), "R2/R3/R4 release edge", fall, exp_release(pre, d, len));
      osc_ok = 1'b1;
   endtask

   // hold window after halt exit (use_mult=0) or multiplier change (use_mult=1)
   task automatic hold_run(input bit use_mult, input int d, input int len, input bit inject);
      int off = use_mult ? 2 : 0;
      int n   = off + d + len + WAIT + 8;
      int low = 0, first = -1, g0;
      string rq = use_mult ? "R6" : "R5";
      @(negedge clk);
      osc_ok = 1'b1;
      if (use_mult) begin mult_wr = 1'b1; mult_wdata = !exp_mult; end
      else halt_exit = 1'b1;
      g0 = gcnt;
      @(posedge clk);
      if (use_mult) exp_mult = !exp_mult;
      @(negedge clk);
      for (int k = 1; k <= n; k++) begin
         if (clk_en_o == 1'b0) begin
            low++;
            if (first < 0) first = k;
         end
         if (k == 1) chk(mult_sel_o == exp_mult, "R6/R8 mult_sel", mult_sel_o, exp_mult);
         osc_ok = !(len > 0 && k - off >= d && k - off < d + len);
         if (inject && k == off + 60) begin
            halt_exit = 1'b1; mult_wr = 1'b1; mult_wdata = !exp_mult;
         end else begin
            halt_exit = 1'b0; mult_wr = 1'b0;
         end
         @(posedge clk);
         @(negedge clk);
      end
      chk(first == off + 3, {rq, " gate start"}, first, off + 3);
      chk(low == exp_low(d, len), {rq, "/R3 gate length"}, low, exp_low(d, len));
      chk(clk_en_o == 1'b1, {rq, " gate reopened"}, clk_en_o, 1);
      chk(gcnt - g0 == 1 + n - low, "R9 gated pulses", gcnt - g0, 1 + n - low);
      if (inject) chk(mult_sel_o == exp_mult, "R8 write in hold ignored", mult_sel_o, exp_mult);
   endtask

   initial begin
      por_n = 1'b0; osc_ok = 1'b0; halt_exit = 1'b0; mult_wr = 1'b0; mult_wdata = 1'b0;
      void'($urandom(32'd20417));
      por_run(0, 0, 0);
      por_run(37, 0, 0);
      por_run(0, 2000, 5);
      // R7: same-value write
      begin
         int low = 0;
         @(negedge clk);
         mult_wr = 1'b1; mult_wdata = exp_mult;
         @(posedge clk);
         @(negedge clk);
         mult_wr = 1'b0;
         for (int k = 0; k < 20; k++) begin
            if (clk_en_o == 1'b0) low++;
            @(negedge clk);
         end
         chk(low == 0, "R7 no gating on same write", low, 0);
         chk(mult_sel_o == exp_mult, "R7 mult_sel kept", mult_sel_o, exp_mult);
      end
      hold_run(1'b0, 0, 0, 1'b1);
      hold_run(1'b1, 0, 0, 1'b1);
      for (int i = 0; i < 6; i++) begin
         int d   = 1 + int'($urandom_range(2999));
         int len = int'($urandom_range(15));
         hold_run(i[0], d, len, 1'b0);
      end
      // R1: reset after a change restores the default multiplier
      por_run(3, 0, 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule